// File: doc/BRIEF.md
# Looping Byte-Sample Waveform Player

This block plays a stored waveform without stopping. Software fills a buffer of 32-bit words, where each word packs four 8-bit samples. It then writes a sample count and a rate divider and pulses a restart strobe. From that point the block unpacks the words one byte at a time and puts each byte on an 8-bit parallel bus. A new byte appears once per sample tick. After the last sample it goes straight back to the first sample, with no gap, so the waveform repeats forever.

The sample tick is the system clock divided by a fixed-point value. The value has a 16-bit integer part and an 8-bit fraction in 1/256 steps. A value below 1.0 is treated as exactly 1.0, which gives one sample per clock cycle. When the rate is not an integer, a phase accumulator adds the fraction once per tick period. Each carry out of the accumulator makes the next period one clock longer. A second channel is built from a second instance.

Top module: `wave_player`

## Requirements
- R1: A restart strobe sampled on clock edge E starts playback at sample 0. The first new sample appears on the edge that is P cycles after E, where P is the effective integer divisor, and `sample_tick` is high for that cycle.
- R2: Sample s is taken from buffer word floor(s/4), bits [8*(s mod 4)+7 : 8*(s mod 4)]. The least significant byte is played first.
- R3: The divider register takes its integer part from bits 31:16 and its fraction, in 1/256 units, from bits 15:8. Bits 7:0 have no effect. An integer part of 0 means a rate of exactly 1.0, and the fraction is then also ignored.
- R4: With a divider of 1.0, a new sample is produced on every clock cycle.
- R5: With integer part I and fraction F, the phase accumulator A starts at 0 on restart. The first period lasts I cycles. At each tick the accumulator adds F; if that addition carries past 255, the following period lasts I+1 cycles, otherwise I cycles.
- R6: A written sample count has its two low bits cleared. The result is then limited to at least 20 and at most 2000. After reset the count is 20.
- R7: After the last sample of the buffer, sample 0 follows after one normal tick period, with no extra delay.
- R8: Between ticks, `sample_out` holds its last value. `sample_tick` is high only in cycles where a new sample has just appeared.
- R9: A restart during playback goes back to sample 0 and clears the rate phase. No sample appears in the cycle after the restart edge.
- R10: A synchronous reset sets `sample_out` to 0x00 and the buffer pointer to 0. The output stays at 0x00, with no ticks, until the first restart strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| buf_we | input | 1 | Buffer word write enable |
| buf_addr | input | 9 | Word address inside the buffer |
| buf_wdata | input | 32 | Four packed samples |
| len_we | input | 1 | Sample count write enable |
| len_val | input | 16 | Requested sample count |
| div_we | input | 1 | Divider register write enable |
| div_val | input | 32 | Divider: integer in 31:16, fraction in 15:8 |
| restart | input | 1 | Restart playback and clear the rate phase |
| sample_out | output | 8 | Current sample |
| sample_tick | output | 1 | High in the cycle a new sample appears |

## Verification
The bench checks both ends of the length range:
- Counts of 7, 103 and 5000 must play as 20, 100 and 2000. A design with the clamp wrong would either wrap after the wrong byte or read words that were never written.
- A full 2000-sample loop must return to the start with no hole. An off-by-one in the wrap logic would repeat a word, skip a word, or stall for a cycle at the buffer end.

The bench checks the rate and the phase:
- The gap before every tick is measured against a model of the phase accumulator. A missing or misplaced carry stretch shows up as a period that is one cycle wrong.
- A divider with a zero integer part must run at full speed.
- A restart in mid-stream must begin again at sample 0 exactly P cycles later. A design that keeps the old phase or pointer would fail this check.

Finally, the byte order is checked on random buffer contents. A design that reverses it would produce a permuted waveform.

// File: rtl/wp_pkg.sv
package wp_pkg;
   localparam int SAMPLE_W = 8;
   localparam int LEN_W    = 16;
   typedef logic [LEN_W-1:0] len_t;

   // round the requested count down to whole words, then bound it
   function automatic len_t fit_len(input len_t raw, input int lo, input int hi, input int step);
      int v;
      v = int'(raw);
      v = v - (v % step);
      if (v < lo) v = lo;
      if (v > hi) v = hi;
      return len_t'(v);
   endfunction
endpackage

// File: rtl/wp_frac_div.sv
module wp_frac_div #(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 8
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              restart,
   input  logic              en,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              tick
);
   localparam int CNT_W = INT_W + 1;

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  end_cnt;
   logic [FRAC_W-1:0] acc;
   logic              stretch;
   logic [INT_W-1:0]  int_eff;
   logic [FRAC_W-1:0] frac_eff;

   // anything below 1.0 behaves as exactly 1.0
   assign int_eff  = (div_int == '0) ? INT_W'(1) : div_int;
   assign frac_eff = (div_int == '0) ? '0 : div_frac;
   assign end_cnt  = {1'b0, int_eff} - CNT_W'(1) + CNT_W'(stretch);
   assign tick     = en && (cnt >= end_cnt);

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt     <= '0;
         acc     <= '0;
         stretch <= 1'b0;
      end else if (tick) begin
         cnt            <= '0;
         {stretch, acc} <= {1'b0, acc} + {1'b0, frac_eff};
      end else if (en) begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/wp_sample_buf.sv
module wp_sample_buf #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 500,
   parameter int ADDR_W = 9
)(
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
   end

   assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/wp_unpack.sv
module wp_unpack #(
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 9,
   parameter int NW_W      = 10,
   parameter bit LSB_FIRST = 1'b1
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              restart,
   input  logic              tick,
   input  logic [NW_W-1:0]   nwords,
   input  logic [WORD_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        sample,
   output logic              sample_tick,
   output logic              running
);
   localparam int BYTES = WORD_W / 8;
   localparam int BI_W  = (BYTES > 1) ? $clog2(BYTES) : 1;

   logic [WORD_W-1:0] sh;
   logic [WORD_W-1:0] sh_shift;
   logic [7:0]        head;
   logic [ADDR_W-1:0] word_ptr;
   logic [BI_W-1:0]   byte_idx;
   logic              last_word;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign head     = sh[7:0];
         assign sh_shift = sh >> 8;
      end else begin : g_msb
         assign head     = sh[WORD_W-1 -: 8];
         assign sh_shift = sh << 8;
      end
   endgenerate

   // word 0 is fetched while the restart strobe is present
   assign rd_addr   = restart ? '0 : word_ptr;
   assign last_word = (NW_W'(word_ptr) + NW_W'(1)) >= nwords;

   always_ff @(posedge clk) begin
      if (rst) begin
         running     <= 1'b0;
         sh          <= '0;
         word_ptr    <= '0;
         byte_idx    <= '0;
         sample      <= '0;
         sample_tick <= 1'b0;
      end else begin
         sample_tick <= 1'b0;
         if (restart) begin
            running  <= 1'b1;
            sh       <= rd_data;
            word_ptr <= ADDR_W'(1);
            byte_idx <= '0;
         end else if (tick) begin
            sample      <= head;
            sample_tick <= 1'b1;
            if (byte_idx == BI_W'(BYTES - 1)) begin
               sh       <= rd_data;
               byte_idx <= '0;
               word_ptr <= last_word ? '0 : word_ptr + ADDR_W'(1);
            end else begin
               sh       <= sh_shift;
               byte_idx <= byte_idx + BI_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/wave_player.sv
module wave_player
   import wp_pkg::*;
#(
   parameter int WORD_W      = 32,
   parameter int MIN_SAMPLES = 20,
   parameter int MAX_SAMPLES = 2000,
   parameter int DIV_INT_W   = 16,
   parameter int DIV_FRAC_W  = 8,
   parameter bit LSB_FIRST   = 1'b1,
   parameter int BYTES       = WORD_W / SAMPLE_W,
   parameter int DEPTH       = MAX_SAMPLES / BYTES,
   parameter int ADDR_W      = $clog2(DEPTH),
   parameter int DIV_W       = DIV_INT_W + 16
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              buf_we,
   input  logic [ADDR_W-1:0] buf_addr,
   input  logic [WORD_W-1:0] buf_wdata,
   input  logic              len_we,
   input  logic [LEN_W-1:0]  len_val,
   input  logic              div_we,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              restart,
   output logic [7:0]        sample_out,
   output logic              sample_tick
);
   localparam int NW_W = ADDR_W + 1;

   initial begin : p_param_chk
      assert (WORD_W % SAMPLE_W == 0 && BYTES >= 2) else $error("word must hold whole samples");
      assert (MIN_SAMPLES % BYTES == 0 && MAX_SAMPLES % BYTES == 0) else $error("limits must be whole words");
      assert (MIN_SAMPLES >= BYTES && MIN_SAMPLES <= MAX_SAMPLES) else $error("bad length limits");
      assert (MAX_SAMPLES < (1 << LEN_W)) else $error("count does not fit the length field");
      assert (DIV_FRAC_W >= 1 && DIV_FRAC_W <= 16) else $error("fraction must fit bits 15:0");
   end

   logic [DIV_W-1:0]      div_q;
   len_t                  len_q;
   logic [NW_W-1:0]       nwords;
   logic [DIV_INT_W-1:0]  div_int;
   logic [DIV_FRAC_W-1:0] div_frac;
   logic                  tick;
   logic                  running;
   logic [ADDR_W-1:0]     rd_addr;
   logic [WORD_W-1:0]     rd_data;

   always_ff @(posedge clk) begin
      if (rst) begin
         div_q <= {{(DIV_INT_W-1){1'b0}}, 1'b1, 16'h0000};
         len_q <= LEN_W'(MIN_SAMPLES);
      end else begin
         if (div_we) div_q <= div_val;
         if (len_we) len_q <= fit_len(len_val, MIN_SAMPLES, MAX_SAMPLES, BYTES);
      end
   end

   assign div_int  = div_q[DIV_W-1 -: DIV_INT_W];
   assign div_frac = div_q[15 -: DIV_FRAC_W];
   assign nwords   = NW_W'(len_q / LEN_W'(BYTES));

   wp_frac_div #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_div (
      .clk(clk), .rst(rst), .restart(restart), .en(running),
      .div_int(div_int), .div_frac(div_frac), .tick(tick)
   );

   wp_sample_buf #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buf (
      .clk(clk), .we(buf_we), .waddr(buf_addr), .wdata(buf_wdata),
      .raddr(rd_addr), .rdata(rd_data)
   );

   wp_unpack #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .NW_W(NW_W), .LSB_FIRST(LSB_FIRST)) u_unp (
      .clk(clk), .rst(rst), .restart(restart), .tick(tick), .nwords(nwords),
      .rd_data(rd_data), .rd_addr(rd_addr), .sample(sample_out),
      .sample_tick(sample_tick), .running(running)
   );
endmodule

// File: rtl/wave_player_chk.sv
module wave_player_chk #(
   parameter int DIV_INT_W = 16,
   parameter int DIV_W     = DIV_INT_W + 16
)(
   input logic             clk,
   input logic             rst,
   input logic             restart,
   input logic             div_we,
   input logic [DIV_W-1:0] div_q,
   input logic             running,
   input logic [7:0]       sample_out,
   input logic             sample_tick
);
   logic [DIV_INT_W-1:0] ifield;
   logic [7:0]           ffield;
   logic                 fast_now;

   assign ifield   = div_q[DIV_W-1 -: DIV_INT_W];
   assign ffield   = div_q[15:8];
   assign fast_now = (ifield == '0) || (ifield == DIV_INT_W'(1) && ffield == 8'h00);

   // R8: output changes only together with the tick flag
   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !sample_tick |-> $stable(sample_out));

   // R9: no sample in the cycle after a restart edge
   a_r9_restart_quiet: assert property (@(posedge clk) disable iff (rst)
      restart |=> !sample_tick);

   // R10: silent and zero until the first restart
   a_r10_idle: assert property (@(posedge clk) disable iff (rst)
      !running |-> (sample_out == 8'h00 && !sample_tick));

   // R5: with an integer part above one, ticks are never back to back
   a_r5_spacing: assert property (@(posedge clk) disable iff (rst)
      (sample_tick && ifield > DIV_INT_W'(1) && !div_we && !restart) |=> !sample_tick);

   // R4: rate 1.0 gives a sample every cycle
   a_r4_fullspeed: assert property (@(posedge clk) disable iff (rst)
      (running && !restart && !div_we && fast_now && $past(fast_now)) |=> sample_tick);
endmodule

bind wave_player wave_player_chk #(.DIV_INT_W(DIV_INT_W)) u_chk (
   .clk(clk), .rst(rst), .restart(restart), .div_we(div_we), .div_q(div_q),
   .running(running), .sample_out(sample_out), .sample_tick(sample_tick)
);

// File: tb/wave_player_tb.sv
module wave_player_tb;
   localparam int MINS  = 20;
   localparam int MAXS  = 2000;
   localparam int DEPTH = 500;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        buf_we = 1'b0;
   logic [8:0]  buf_addr = '0;
   logic [31:0] buf_wdata = '0;
   logic        len_we = 1'b0;
   logic [15:0] len_val = '0;
   logic        div_we = 1'b0;
   logic [31:0] div_val = '0;
   logic        restart = 1'b0;
   logic [7:0]  sample_out;
   logic        sample_tick;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [31:0] model [DEPTH];

   always #10 clk = ~clk;

   wave_player u_dut (
      .clk(clk), .rst(rst), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .len_we(len_we), .len_val(len_val), .div_we(div_we), .div_val(div_val),
      .restart(restart), .sample_out(sample_out), .sample_tick(sample_tick)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int fit(input int raw);
      int v;
      v = raw - (raw % 4);
      if (v < MINS) v = MINS;
      if (v > MAXS) v = MAXS;
      return v;
   endfunction

   function automatic int exp_sample(input int s, input int len);
      int p;
      logic [31:0] w;
      p = s % len;
      w = model[p / 4];
      return int'(w[(p % 4) * 8 +: 8]);
   endfunction

   // all driving tasks start and end on a falling edge
   task automatic wr_word(input int a, input logic [31:0] d);
      buf_we = 1'b1; buf_addr = 9'(a); buf_wdata = d;
      model[a] = d;
      @(negedge clk);
      buf_we = 1'b0;
   endtask

   task automatic set_len(input int v);
      len_we = 1'b1; len_val = 16'(v);
      @(negedge clk);
      len_we = 1'b0;
   endtask

   task automatic set_div(input logic [31:0] v);
      div_we = 1'b1; div_val = v;
      @(negedge clk);
      div_we = 1'b0;
   endtask

   // restart, then follow n ticks against the rate and sample model
   task automatic play(input int n, input int len_e, input logic [31:0] dv,
                       input string gtag, input string ftag, input string vtag);
      int ie, fe, acc, sum, gap, cyc, k, held;
      ie = int'(dv[31:16]);
      fe = int'(dv[15:8]);
      if (ie == 0) begin ie = 1; fe = 0; end
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      held = int'(sample_out);
      acc = 0; gap = ie; cyc = 0; k = 0;
      while (k < n) begin
         @(negedge clk);
         cyc++;
         if (sample_tick) begin
            chk(cyc == gap, (k == 0) ? ftag : gtag, "tick spacing", cyc, gap);
            chk(int'(sample_out) == exp_sample(k, len_e), (k >= len_e) ? "R7" : vtag,
                "sample value", int'(sample_out), exp_sample(k, len_e));
            held = int'(sample_out);
            sum = acc + fe;
            acc = sum % 256;
            gap = ie + sum / 256;
            cyc = 0;
            k++;
         end else begin
            chk(int'(sample_out) == held, "R8", "held value", int'(sample_out), held);
            if (cyc > gap) begin
               chk(1'b0, gtag, "missing tick", cyc, gap);
               k = n;
            end
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned sd;
      int raw, le;
      logic [31:0] dv;
      sd = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R10: quiet after reset
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(sample_out == 8'h00 && !sample_tick, "R10", "reset output", int'(sample_out), 0);
      end

      for (int i = 0; i < DEPTH; i++) wr_word(i, $urandom);
      set_div(32'h0001_0000);
      repeat (5) @(negedge clk);
      // R10: still quiet without a restart
      chk(sample_out == 8'h00 && !sample_tick, "R10", "no play before restart", int'(sample_out), 0);

      // R4 R1 R2 R7: full speed, reset length of 20
      play(50, MINS, 32'h0001_0000, "R4", "R1", "R2");

      // R6: small count clamps up to 20
      set_len(7);
      play(45, fit(7), 32'h0001_0000, "R4", "R1", "R6");
      // R6: low bits cleared, 103 plays as 100
      set_len(103);
      play(210, fit(103), 32'h0001_0000, "R4", "R1", "R6");
      // R6 R7: large count clamps down to 2000, full loop and wrap
      set_len(5000);
      play(2010, fit(5000), 32'h0001_0000, "R4", "R1", "R6");

      // R5 R3: 3.25 with junk in bits 7:0
      set_len(40);
      set_div(32'h0003_40FF);
      play(50, 40, 32'h0003_40FF, "R5", "R3", "R2");
      // R3: integer part 0 means exactly 1.0
      set_div(32'h0000_8000);
      play(30, 40, 32'h0000_8000, "R3", "R3", "R2");

      // R9: restart in mid stream, twice
      set_div(32'h0002_C000);
      play(23, 40, 32'h0002_C000, "R5", "R1", "R2");
      play(23, 40, 32'h0002_C000, "R5", "R9", "R9");
      set_div(32'h0001_0000);
      play(13, 40, 32'h0001_0000, "R4", "R9", "R9");

      // random rounds
      for (int r = 0; r < 8; r++) begin
         for (int j = 0; j < 3; j++) wr_word($urandom_range(0, DEPTH - 1), $urandom);
         raw = $urandom_range(0, 400);
         le = fit(raw);
         dv = {16'($urandom_range(1, 5)), 8'($urandom_range(0, 255)), 8'($urandom_range(0, 255))};
         set_len(raw);
         set_div(dv);
         play(le + 8, le, dv, "R5", "R1", "R6");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule